// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block collects the interrupt causes of a UART (receive line errors, received data ready, receive timeout, transmit holding register empty and modem-line changes) and reduces them to one interrupt request and a 4-bit identification code. Software sets a write/read enable register that masks the causes. When software reads the identification register, it sees the most urgent cause that is both pending and enabled.

The receiver supplies two levels: "data at or above trigger" and "timeout". It also pulses an error event. The modem detector pulses a change event. The transmitter supplies a "holding register empty" level. The block keeps the error, modem and transmit-empty causes in sticky flags and clears each one on the register access that services it. Addresses used: 0 = data (a write loads the transmit holding register), 1 = enable, 2 = identification, 5 = line status, 6 = modem status.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the identification code is 4'b0001, the interrupt output is low, and the enable register reads 0.
- R2: A write to address 1 loads enable bits [3:0]: bit 0 = data-ready and timeout, bit 1 = transmit-empty, bit 2 = line error, bit 3 = modem change. Reading address 1 returns these bits, and bits [7:4] always read 0.
- R3: With no enabled cause pending, the code is 4'b0001. The interrupt output is high exactly when code bit 0 is 0. Reading address 2 returns the code in bits [3:0] and zero above.
- R4: An enabled line error has top priority and reports code 4'b0110. The error flag stays set until address 5 is read. An error event in the same cycle as that read keeps the flag set.
- R5: While the data-ready level is high and enable bit 0 is set, and no higher cause is pending, the code is 4'b0100.
- R6: While the timeout level is high and enable bit 0 is set, the code is 4'b1100. The timeout shares the data-ready level and is reported over data-ready when both are high.
- R7: Transmit-empty ranks third and reports code 4'b0010. Its flag is set on a rising edge of the holding-empty input. It is also set when a write to address 1 turns enable bit 1 from 0 to 1 while the holding register is empty.
- R8: The transmit-empty flag clears when address 2 is read while the code is 4'b0010, or when address 0 is written. A clear in the same cycle as a set leaves the flag clear.
- R9: An enabled modem change has the lowest priority and reports code 4'b0000. Its flag stays set until address 6 is read. An event in the same cycle as that read keeps the flag set.
- R10: Masking a sticky cause hides it from the code and the interrupt output without clearing it. Re-enabling the cause shows it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the enable and identification registers, zero elsewhere |
| line_err_evt | input | 1 | One-cycle pulse: framing, parity, overrun or break seen |
| rx_avail | input | 1 | Level: received data at or above trigger |
| rx_timeout | input | 1 | Level: receive timeout |
| tx_empty | input | 1 | Level: transmit holding register empty |
| modem_evt | input | 1 | One-cycle pulse: a modem input changed |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Identification code |

## Verification
A directed prelude drives the cases where one cause competes with another: error against timeout against data-ready, and transmit-empty against a modem change. These cases show whether the priority order and the exact code values are right. It also drives the cases where a clear meets a new event in the same cycle. These show whether the set-wins rule (errors, modem) and the clear-wins rule (transmit-empty) are applied to the correct flag. Seeded random traffic then mixes register accesses, event pulses and level toggles. This exposes wrong clear addresses, wrong enable bit mapping and masking that drops a sticky flag.

// File: rtl/uart_irq_pkg.sv
// Shared codes, addresses and the pending-cause record for the UART
// interrupt prioritizer. Assumes a 3-bit register address space.
package uart_irq_pkg;
    localparam int A_DATA = 0;
    localparam int A_IEN  = 1;
    localparam int A_IID  = 2;
    localparam int A_LSR  = 5;
    localparam int A_MSR  = 6;

    localparam logic [3:0] IID_NONE = 4'b0001;
    localparam logic [3:0] IID_ERR  = 4'b0110;
    localparam logic [3:0] IID_RDA  = 4'b0100;
    localparam logic [3:0] IID_TMO  = 4'b1100;
    localparam logic [3:0] IID_TXE  = 4'b0010;
    localparam logic [3:0] IID_MDM  = 4'b0000;

    typedef struct packed {
        logic mdm;
        logic txe;
        logic tmo;
        logic rda;
        logic err;
    } irq_pend_t;
endpackage

// File: rtl/irq_sticky.sv
// Sticky interrupt flag. SET_WINS picks which request wins when set and
// clear arrive together. Assumes set/clear are single-cycle qualified strobes.
module irq_sticky #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_next;

    generate
        if (SET_WINS) begin : g_set_wins
            // Next state: a new event outranks the service clear.
            always_comb q_next = set_i | (q_o & ~clr_i);

            p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
                set_i |=> q_o);
        end else begin : g_clr_wins
            // Next state: the service clear outranks a new event.
            always_comb q_next = ~clr_i & (set_i | q_o);

            p_clr_beats_r8: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> !q_o);
        end
    endgenerate

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_next;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder from masked pending causes to the 4-bit code.
// Assumes inputs are already ANDed with their enable bits.
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_pend_t  pend_i,
    output logic [3:0] code_o
);
    // Pick the most urgent cause; timeout outranks data-ready within level two.
    always_comb begin
        if (pend_i.err)      code_o = IID_ERR;
        else if (pend_i.tmo) code_o = IID_TMO;
        else if (pend_i.rda) code_o = IID_RDA;
        else if (pend_i.txe) code_o = IID_TXE;
        else if (pend_i.mdm) code_o = IID_MDM;
        else                 code_o = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// UART interrupt prioritizer top: enable register, sticky cause flags,
// priority encoding and register read mux. Assumes reg_rd and reg_wr are
// single-cycle strobes and tx_empty is idle-high after reset.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              line_err_evt,
    input  logic              rx_avail,
    input  logic              rx_timeout,
    input  logic              tx_empty,
    input  logic              modem_evt,
    output logic              irq,
    output logic [3:0]        iid
);
    localparam int EN_W  = 4;
    localparam int IID_W = 4;

    logic [EN_W-1:0] en_q;
    logic            tx_q;
    logic            err_f, mdm_f, txe_f;
    logic            wr_ien, rd_iid, rd_lsr, rd_msr, wr_data;
    logic            tx_set, tx_clr;
    irq_pend_t       pend;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:EN_W];

    // Decode register strobes.
    assign wr_ien  = reg_wr && (reg_addr == ADDR_W'(A_IEN));
    assign wr_data = reg_wr && (reg_addr == ADDR_W'(A_DATA));
    assign rd_iid  = reg_rd && (reg_addr == ADDR_W'(A_IID));
    assign rd_lsr  = reg_rd && (reg_addr == ADDR_W'(A_LSR));
    assign rd_msr  = reg_rd && (reg_addr == ADDR_W'(A_MSR));

    // Enable register and previous holding-empty level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            tx_q <= 1'b1;
        end else begin
            if (wr_ien) en_q <= reg_wdata[EN_W-1:0];
            tx_q <= tx_empty;
        end
    end

    // Transmit-empty arm and service conditions.
    assign tx_set = (tx_empty && !tx_q) ||
                    (wr_ien && reg_wdata[1] && !en_q[1] && tx_empty);
    assign tx_clr = wr_data || (rd_iid && (iid == IID_TXE));

    irq_sticky #(.SET_WINS(1'b1)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(line_err_evt), .clr_i(rd_lsr), .q_o(err_f));
    irq_sticky #(.SET_WINS(1'b1)) u_mdm (
        .clk(clk), .rst_n(rst_n), .set_i(modem_evt), .clr_i(rd_msr), .q_o(mdm_f));
    irq_sticky #(.SET_WINS(1'b0)) u_txe (
        .clk(clk), .rst_n(rst_n), .set_i(tx_set), .clr_i(tx_clr), .q_o(txe_f));

    // Mask causes with their enable bits.
    always_comb begin
        pend.err = err_f      & en_q[2];
        pend.rda = rx_avail   & en_q[0];
        pend.tmo = rx_timeout & en_q[0];
        pend.txe = txe_f      & en_q[1];
        pend.mdm = mdm_f      & en_q[3];
    end

    irq_prio_enc u_enc (.pend_i(pend), .code_o(iid));

    assign irq = ~iid[0];

    // Read mux for the two registers owned here.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_IEN))      reg_rdata[EN_W-1:0]  = en_q;
        else if (reg_addr == ADDR_W'(A_IID)) reg_rdata[IID_W-1:0] = iid;
    end

    p_err_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_f && en_q[2]) |-> (iid == IID_ERR));
    p_rda_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && en_q[0] && !rx_timeout && !(err_f && en_q[2])) |-> (iid == IID_RDA));
    p_ien_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(A_IEN)) |-> (reg_rdata[DATA_W-1:EN_W] == '0));
    p_txe_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iid && iid == IID_TXE) |=> (iid != IID_TXE));
    p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_f || rx_avail || rx_timeout || txe_f || mdm_f) |-> (iid == IID_NONE && !irq));
endmodule

// File: tb/uart_irq_prio_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, against a
// cycle model derived from the requirements.
module uart_irq_prio_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic       line_err_evt, rx_avail, rx_timeout, tx_empty, modem_evt;
    logic       irq;
    logic [3:0] iid;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Model state.
    logic [3:0] m_en;
    logic       m_err, m_mdm, m_txe, m_txq;

    always #4 clk = ~clk;

    uart_irq_prio dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_err_evt(line_err_evt), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .tx_empty(tx_empty), .modem_evt(modem_evt), .irq(irq), .iid(iid));

    function automatic logic [3:0] exp_code(logic [3:0] en, logic err, logic av,
                                            logic tmo, logic txe, logic mdm);
        if (err && en[2])      return 4'b0110;
        else if (tmo && en[0]) return 4'b1100;
        else if (av && en[0])  return 4'b0100;
        else if (txe && en[1]) return 4'b0010;
        else if (mdm && en[3]) return 4'b0000;
        else                   return 4'b0001;
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a, logic [3:0] en, logic [3:0] c);
        if (a == 3'd1)      return {4'b0, en};
        else if (a == 3'd2) return {4'b0, c};
        else                return 8'h00;
    endfunction

    // One cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input string tag, input logic [2:0] a, input logic wr,
                        input logic rd, input logic [7:0] wd,
                        input logic ev_err, input logic ev_mdm);
        logic [3:0] cur, nxt;
        logic       set_t, clr_t, bad;
        reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        line_err_evt = ev_err; modem_evt = ev_mdm;
        cur   = exp_code(m_en, m_err, rx_avail, rx_timeout, m_txe, m_mdm);
        set_t = (tx_empty && !m_txq) || (wr && a == 3'd1 && wd[1] && !m_en[1] && tx_empty);
        clr_t = (wr && a == 3'd0) || (rd && a == 3'd2 && cur == 4'b0010);
        @(posedge clk);
        m_err = ev_err | (m_err & ~(rd && a == 3'd5));
        m_mdm = ev_mdm | (m_mdm & ~(rd && a == 3'd6));
        m_txe = ~clr_t & (set_t | m_txe);
        if (wr && a == 3'd1) m_en = wd[3:0];
        m_txq = tx_empty;
        @(negedge clk);
        nxt = exp_code(m_en, m_err, rx_avail, rx_timeout, m_txe, m_mdm);
        vectors++;
        bad = (iid !== nxt) || (irq !== ~nxt[0]) || (reg_rdata !== exp_rd(a, m_en, nxt));
        if (bad) begin
            errors++;
            $display("FAIL %s: iid=%b irq=%b rdata=%h exp iid=%b irq=%b rdata=%h",
                     tag, iid, irq, reg_rdata, nxt, ~nxt[0], exp_rd(a, m_en, nxt));
        end
        reg_wr = 1'b0; reg_rd = 1'b0; line_err_evt = 1'b0; modem_evt = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [2:0] addrs [6];
        seed = $urandom(32'd2024);
        addrs = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6};
        rst_n = 1'b0; reg_addr = 3'd1; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
        line_err_evt = 0; modem_evt = 0; rx_avail = 0; rx_timeout = 0; tx_empty = 1;
        m_en = 0; m_err = 0; m_mdm = 0; m_txe = 0; m_txq = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, read enable register
        step("R1", 3'd1, 0, 1, 8'h00, 0, 0);
        // R3: idle code read back through address 2
        step("R3", 3'd2, 0, 1, 8'h00, 0, 0);
        // R2: all-ones write, upper bits must read zero; R7 arms on enable
        step("R2", 3'd1, 1, 0, 8'hFF, 0, 0);
        step("R2", 3'd1, 0, 1, 8'h00, 0, 0);
        // R7 outranks a modem change (R9)
        step("R7", 3'd3, 0, 0, 8'h00, 0, 1);
        // R8: reading the code while it reports transmit-empty clears it
        step("R8", 3'd2, 0, 1, 8'h00, 0, 0);
        // R9: modem cause now visible, then serviced
        step("R9", 3'd6, 0, 1, 8'h00, 0, 1);
        step("R9", 3'd6, 0, 1, 8'h00, 0, 0);
        rx_avail = 1;
        step("R5", 3'd3, 0, 0, 8'h00, 0, 0);
        rx_timeout = 1;
        step("R6", 3'd3, 0, 0, 8'h00, 0, 0);
        step("R4", 3'd3, 0, 0, 8'h00, 1, 0);
        step("R4", 3'd5, 0, 1, 8'h00, 1, 0);
        step("R4", 3'd5, 0, 1, 8'h00, 0, 0);
        // R10: mask data-ready/timeout, set error, then re-enable
        step("R10", 3'd1, 1, 0, 8'h0A, 0, 0);
        step("R10", 3'd3, 0, 0, 8'h00, 1, 0);
        step("R10", 3'd1, 1, 0, 8'h0F, 0, 0);
        step("R4", 3'd5, 0, 1, 8'h00, 0, 0);
        rx_avail = 0; rx_timeout = 0;
        step("R3", 3'd2, 0, 1, 8'h00, 0, 0);
        // R7: rising holding-empty level arms the flag
        tx_empty = 0;
        step("R7", 3'd3, 0, 0, 8'h00, 0, 0);
        tx_empty = 1;
        step("R7", 3'd3, 0, 0, 8'h00, 0, 0);
        // R8: data write clears; clear beats a same-cycle rise
        step("R8", 3'd0, 1, 0, 8'h55, 0, 0);
        tx_empty = 0;
        step("R8", 3'd3, 0, 0, 8'h00, 0, 0);
        tx_empty = 1;
        step("R8", 3'd0, 1, 0, 8'hAA, 0, 0);
        // Random traffic across all requirements.
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] a;
            r = $urandom_range(0, 9);
            a = addrs[$urandom_range(0, 5)];
            if ($urandom_range(0, 7) == 0) rx_avail   = ~rx_avail;
            if ($urandom_range(0, 9) == 0) rx_timeout = ~rx_timeout;
            if ($urandom_range(0, 5) == 0) tx_empty   = ~tx_empty;
            step("R3", a, r < 2, (r >= 2 && r < 5), 8'($urandom),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule